// File: doc/BRIEF.md
# Strobed Serial Word Loader for a Dual Synthesiser

This block receives configuration words for a dual frequency synthesiser over a three-wire bus: a data line, a bit clock and a load strobe. All three wires are asynchronous to the system clock. They pass through a synchroniser, and the block acts only on edges it sees after synchronisation. Bits enter a shift register on each rising edge of the bit clock, most significant bit first. A bit counter counts them. When the strobe rises, the counter and the last-shifted address bits decide where the word goes, and the counter clears.

There are four 24-bit words (A, B, C, D) and one 32-bit word (A2). Word B is not applied when it arrives. It waits in a staging register and reaches its working register only when the next A or A2 is loaded. Loading A or A2 also raises a speed-up indication for the main loop, which stays up while the strobe is held high. While the strobe is high, bit-clock pulses are ignored. Each working register that changes gets a one-cycle update pulse. A strobe whose bit count matches no word changes nothing and raises an error flag.

The control is a three-state machine:
- `ST_COLLECT` accepts bits.
- `ST_HOLD` is the strobe-high state after a B, C or D word or a rejected frame.
- `ST_BOOST` is the strobe-high state after an A or A2 word.

Transitions: `ST_COLLECT` goes to `ST_BOOST` on a strobe rise that decodes as A or A2. `ST_COLLECT` goes to `ST_HOLD` on any other strobe rise. Both `ST_HOLD` and `ST_BOOST` return to `ST_COLLECT` once the synchronised strobe is low.

Top module: `serial_prog_port`

## Requirements
- R1: While the synchronised strobe is low, each synchronised rising edge of `ser_clk` shifts `ser_dat` in as the new least significant bit, so the first bit sent ends up most significant.
- R2: A strobe after exactly 24 bits whose two last-shifted bits are `00` loads those 24 bits into `word_a`.
- R3: A 24-bit word with address `10` loads `word_c`, and one with address `11` loads `word_d`. No other word changes C or D.
- R4: A 24-bit word with address `01` goes to a staging register. `word_b` does not change and no update pulse is produced.
- R5: The next load of A or A2 copies a staged B into `word_b` in the same cycle as the A/A2 update. The stage is then empty, so a later A does not pulse B again.
- R6: A strobe after exactly 32 bits with address `00` loads `word_a2`. Only such a frame changes `word_a2`.
- R7: `speedup` rises in the cycle of an A or A2 load and stays high until the synchronised strobe falls. It is never high for B, C or D, or for a rejected frame.
- R8: Bit-clock pulses while the strobe is high neither shift nor count. A word sent after such a strobe decodes exactly as if no pulses had occurred.
- R9: A strobe with any other bit count, or a 32-bit frame with a non-zero address, changes no register and sets `frame_err`. The next valid strobe clears `frame_err`.
- R10: After reset all words are zero, `word_upd` is zero, `speedup` and `frame_err` are low, and no B is staged.
- R11: `word_upd` bit 0 marks A, bit 1 A2, bit 2 B, bit 3 C and bit 4 D. Each bit is a single-cycle pulse in the cycle its register changes.
- R12: Inputs pass two synchroniser stages. The register change, pulse and `speedup` all appear on the third system-clock edge after the strobe pin is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_stb | input | 1 | Load strobe, asynchronous |
| word_a | output | SHORT_W | Working register A |
| word_a2 | output | LONG_W | Working register A2 |
| word_b | output | SHORT_W | Working register B (applied copy) |
| word_c | output | SHORT_W | Working register C |
| word_d | output | SHORT_W | Working register D |
| word_upd | output | 5 | Per-register update pulses (A, A2, B, C, D from bit 0) |
| speedup | output | 1 | Main-loop speed-up indication |
| frame_err | output | 1 | Last strobe carried an unrecognised frame |

## Verification
The bench sends each word kind in turn with distinct bit patterns, so a reversed bit order or a wrong address decode shows up as a wrong value. A B-then-A and a B-then-A2 sequence separate correct staging from immediate loading. A following plain A shows whether the stage really empties. Frames of 20 bits and 32-bit frames with a bad address test rejection. A strobe carrying extra bit-clock pulses, followed by an exact-length word, shows whether clocks under the strobe are truly ignored.

// File: rtl/spp_pkg.sv
package spp_pkg;

    typedef enum logic [1:0] {
        ST_COLLECT,
        ST_HOLD,
        ST_BOOST
    } port_state_e;

    typedef enum logic [2:0] {
        WK_A,
        WK_A2,
        WK_B,
        WK_C,
        WK_D,
        WK_BAD
    } word_kind_e;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_A = 2'b00;
    localparam logic [ADDR_W-1:0] ADDR_B = 2'b01;
    localparam logic [ADDR_W-1:0] ADDR_C = 2'b10;
    localparam logic [ADDR_W-1:0] ADDR_D = 2'b11;

    localparam int UPD_A  = 0;
    localparam int UPD_A2 = 1;
    localparam int UPD_B  = 2;
    localparam int UPD_C  = 3;
    localparam int UPD_D  = 4;
    localparam int UPD_N  = 5;

endpackage

// File: rtl/spp_sync_edge.sv
module spp_sync_edge #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter int EDGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  din,
    output logic [WIDTH-1:0]  lvl,
    output logic [EDGE_W-1:0] rise
);

    logic [STAGES-1:0][WIDTH-1:0] chain;
    logic [EDGE_W-1:0]            last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= '0;
        end else begin
            chain[0] <= din;
            for (int i = STAGES - 1; i > 0; i--) begin
                chain[i] <= chain[i-1];
            end
            last <= chain[STAGES-1][EDGE_W-1:0];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1][EDGE_W-1:0] & ~last;

endmodule

// File: rtl/spp_shift_collect.sv
module spp_shift_collect #(
    parameter int LONG_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              clr_cnt,
    output logic [LONG_W-1:0] shreg,
    output logic [CNT_W-1:0]  bit_cnt
);

    localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(LONG_W + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (clr_cnt) begin
            bit_cnt <= '0;
        end else if (shift_en) begin
            shreg <= {shreg[LONG_W-2:0], bit_in};
            if (bit_cnt != CNT_CAP) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spp_word_decode.sv
module spp_word_decode
    import spp_pkg::*;
#(
    parameter int SHORT_W = 24,
    parameter int LONG_W  = 32,
    parameter int CNT_W   = 6
) (
    input  logic [LONG_W-1:0] shreg,
    input  logic [CNT_W-1:0]  bit_cnt,
    output word_kind_e        kind
);

    localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(SHORT_W);
    localparam logic [CNT_W-1:0] LONG_CNT  = CNT_W'(LONG_W);

    logic [ADDR_W-1:0] tag;
    assign tag = shreg[ADDR_W-1:0];

    always_comb begin
        kind = WK_BAD;
        if (bit_cnt == SHORT_CNT) begin
            unique case (tag)
                ADDR_A:  kind = WK_A;
                ADDR_B:  kind = WK_B;
                ADDR_C:  kind = WK_C;
                ADDR_D:  kind = WK_D;
                default: kind = WK_BAD;
            endcase
        end else if (bit_cnt == LONG_CNT && tag == ADDR_A) begin
            kind = WK_A2;
        end
    end

endmodule

// File: rtl/spp_word_bank.sv
module spp_word_bank
    import spp_pkg::*;
#(
    parameter int SHORT_W = 24,
    parameter int LONG_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  word_kind_e         kind,
    input  logic [LONG_W-1:0]  shreg,
    output logic [SHORT_W-1:0] word_a,
    output logic [LONG_W-1:0]  word_a2,
    output logic [SHORT_W-1:0] word_b,
    output logic [SHORT_W-1:0] word_c,
    output logic [SHORT_W-1:0] word_d,
    output logic [UPD_N-1:0]   word_upd
);

    logic [SHORT_W-1:0] b_stage;
    logic               b_pend;
    logic               main_load;

    assign main_load = commit && (kind == WK_A || kind == WK_A2);

    // staging of B and its release on a main-word load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_stage <= '0;
            b_pend  <= 1'b0;
            word_b  <= '0;
        end else if (commit && kind == WK_B) begin
            b_stage <= shreg[SHORT_W-1:0];
            b_pend  <= 1'b1;
        end else if (main_load && b_pend) begin
            word_b <= b_stage;
            b_pend <= 1'b0;
        end
    end

    // directly loaded working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_a  <= '0;
            word_a2 <= '0;
            word_c  <= '0;
            word_d  <= '0;
        end else if (commit) begin
            unique case (kind)
                WK_A:    word_a  <= shreg[SHORT_W-1:0];
                WK_A2:   word_a2 <= shreg;
                WK_C:    word_c  <= shreg[SHORT_W-1:0];
                WK_D:    word_d  <= shreg[SHORT_W-1:0];
                default: ;
            endcase
        end
    end

    // update pulses, one cycle each
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_upd <= '0;
        end else begin
            word_upd         <= '0;
            word_upd[UPD_B]  <= main_load && b_pend;
            if (commit) begin
                word_upd[UPD_A]  <= (kind == WK_A);
                word_upd[UPD_A2] <= (kind == WK_A2);
                word_upd[UPD_C]  <= (kind == WK_C);
                word_upd[UPD_D]  <= (kind == WK_D);
            end
        end
    end

endmodule

// File: rtl/serial_prog_port.sv
module serial_prog_port
    import spp_pkg::*;
#(
    parameter int SHORT_W     = 24,
    parameter int LONG_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               ser_stb,
    output logic [SHORT_W-1:0] word_a,
    output logic [LONG_W-1:0]  word_a2,
    output logic [SHORT_W-1:0] word_b,
    output logic [SHORT_W-1:0] word_c,
    output logic [SHORT_W-1:0] word_d,
    output logic [UPD_N-1:0]   word_upd,
    output logic               speedup,
    output logic               frame_err
);

    localparam int CNT_W = $clog2(LONG_W + 2);

    logic [2:0]        pin_lvl;
    logic [1:0]        pin_rise;
    logic              stb_lvl, stb_rise, clk_rise, dat_lvl;
    logic [LONG_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    word_kind_e        kind;
    port_state_e       state_q, state_d;
    logic              shift_en, commit, collecting;

    spp_sync_edge #(
        .WIDTH (3),
        .STAGES(SYNC_STAGES),
        .EDGE_W(2)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_dat, ser_stb, ser_clk}),
        .lvl  (pin_lvl),
        .rise (pin_rise)
    );

    assign dat_lvl  = pin_lvl[2];
    assign stb_lvl  = pin_lvl[1];
    assign stb_rise = pin_rise[1];
    assign clk_rise = pin_rise[0];

    spp_shift_collect #(
        .LONG_W(LONG_W),
        .CNT_W (CNT_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .bit_in  (dat_lvl),
        .clr_cnt (commit),
        .shreg   (shreg),
        .bit_cnt (bit_cnt)
    );

    spp_word_decode #(
        .SHORT_W(SHORT_W),
        .LONG_W (LONG_W),
        .CNT_W  (CNT_W)
    ) u_decode (
        .shreg  (shreg),
        .bit_cnt(bit_cnt),
        .kind   (kind)
    );

    spp_word_bank #(
        .SHORT_W(SHORT_W),
        .LONG_W (LONG_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .kind    (kind),
        .shreg   (shreg),
        .word_a  (word_a),
        .word_a2 (word_a2),
        .word_b  (word_b),
        .word_c  (word_c),
        .word_d  (word_d),
        .word_upd(word_upd)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COLLECT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: begin
                if (stb_rise) begin
                    state_d = (kind == WK_A || kind == WK_A2) ? ST_BOOST : ST_HOLD;
                end
            end
            ST_HOLD, ST_BOOST: begin
                if (!stb_lvl) begin
                    state_d = ST_COLLECT;
                end
            end
            default: state_d = ST_COLLECT;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        collecting = (state_q == ST_COLLECT);
        speedup    = (state_q == ST_BOOST);
        commit     = collecting && stb_rise;
        shift_en   = collecting && clk_rise && !stb_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_err <= 1'b0;
        end else if (commit) begin
            frame_err <= (kind == WK_BAD);
        end
    end

endmodule

// File: rtl/serial_prog_port_chk.sv
module serial_prog_port_chk
    import spp_pkg::*;
#(
    parameter int SHORT_W = 24,
    parameter int LONG_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               speedup,
    input logic               frame_err,
    input logic [UPD_N-1:0]   word_upd,
    input logic [LONG_W-1:0]  word_a2,
    input logic [SHORT_W-1:0] word_b,
    input logic [SHORT_W-1:0] word_c,
    input logic               collecting,
    input logic [LONG_W-1:0]  shreg
);

    assert_b_with_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_upd[UPD_B] |-> (word_upd[UPD_A] || word_upd[UPD_A2]));

    assert_boost_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(speedup) |-> (word_upd[UPD_A] || word_upd[UPD_A2]));

    assert_boost_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        speedup |-> !frame_err);

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (word_upd != '0) |=> ((word_upd & $past(word_upd)) == '0));

    assert_c_guarded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_c != $past(word_c)) |-> word_upd[UPD_C]);

    assert_b_guarded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_b != $past(word_b)) |-> word_upd[UPD_B]);

    assert_a2_guarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_a2 != $past(word_a2)) |-> word_upd[UPD_A2]);

    assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !collecting |=> $stable(shreg));

endmodule

bind serial_prog_port serial_prog_port_chk #(
    .SHORT_W(SHORT_W),
    .LONG_W (LONG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .speedup   (speedup),
    .frame_err (frame_err),
    .word_upd  (word_upd),
    .word_a2   (word_a2),
    .word_b    (word_b),
    .word_c    (word_c),
    .collecting(collecting),
    .shreg     (shreg)
);

// File: tb/tb_serial_prog_port.sv
`timescale 1ns/1ps
module tb_serial_prog_port;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_stb = 1'b0;
    logic [23:0] word_a, word_b, word_c, word_d;
    logic [31:0] word_a2;
    logic [4:0]  word_upd;
    logic        speedup, frame_err;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    serial_prog_port dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_stb(ser_stb), .word_a(word_a), .word_a2(word_a2), .word_b(word_b),
        .word_c(word_c), .word_d(word_d), .word_upd(word_upd),
        .speedup(speedup), .frame_err(frame_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference model: pin history queue, integers for counts
    logic [2:0]  hist[$] = '{3'b000, 3'b000, 3'b000};
    logic [31:0] m_sr;
    int          m_cnt;
    bit          m_hold, m_boost, m_err, m_bp;
    logic [23:0] ma, mb, mc, md, mbt;
    logic [31:0] ma2;
    logic [4:0]  mupd;

    initial begin
        m_sr = 0; m_cnt = 0; m_hold = 0; m_boost = 0; m_err = 0; m_bp = 0;
        ma = 0; mb = 0; mc = 0; md = 0; mbt = 0; ma2 = 0; mupd = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sr = 0; m_cnt = 0; m_hold = 0; m_boost = 0; m_err = 0; m_bp = 0;
            ma = 0; mb = 0; mc = 0; md = 0; mbt = 0; ma2 = 0; mupd = 0;
            hist = '{3'b000, 3'b000, 3'b000};
        end else begin
            logic [2:0] now2, now3;
            int tag;
            now2 = hist[1];
            now3 = hist[2];
            mupd = 0;
            if (!m_hold) begin
                if (now2[2] && !now3[2]) begin
                    tag = int'(m_sr[1:0]);
                    m_hold = 1; m_boost = 0; m_err = 0;
                    if (m_cnt == 24 && tag == 0) begin
                        ma = m_sr[23:0]; mupd[0] = 1; m_boost = 1;
                    end else if (m_cnt == 32 && tag == 0) begin
                        ma2 = m_sr; mupd[1] = 1; m_boost = 1;
                    end else if (m_cnt == 24 && tag == 1) begin
                        mbt = m_sr[23:0]; m_bp = 1;
                    end else if (m_cnt == 24 && tag == 2) begin
                        mc = m_sr[23:0]; mupd[3] = 1;
                    end else if (m_cnt == 24 && tag == 3) begin
                        md = m_sr[23:0]; mupd[4] = 1;
                    end else begin
                        m_err = 1;
                    end
                    if (m_boost && m_bp) begin
                        mb = mbt; m_bp = 0; mupd[2] = 1;
                    end
                    m_cnt = 0;
                end else if (now2[1] && !now3[1] && !now2[2]) begin
                    m_sr = {m_sr[30:0], now2[0]};
                    if (m_cnt < 33) m_cnt++;
                end
            end else if (!now2[2]) begin
                m_hold = 0;
                m_boost = 0;
            end
            hist.push_front({ser_stb, ser_clk, ser_dat});
            void'(hist.pop_back());
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!finished && rst_n) begin
            check(word_a == ma,   "R1 R2 word_a",  {8'h0, word_a}, {8'h0, ma});
            check(word_a2 == ma2, "R6 word_a2",    word_a2, ma2);
            check(word_b == mb,   "R4 R5 word_b",  {8'h0, word_b}, {8'h0, mb});
            check(word_c == mc,   "R3 word_c",     {8'h0, word_c}, {8'h0, mc});
            check(word_d == md,   "R3 word_d",     {8'h0, word_d}, {8'h0, md});
            check(word_upd == mupd, "R11 R12 word_upd", {27'h0, word_upd}, {27'h0, mupd});
            check(speedup == m_boost, "R7 speedup", {31'h0, speedup}, {31'h0, m_boost});
            check(frame_err == m_err, "R9 frame_err", {31'h0, frame_err}, {31'h0, m_err});
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            idle(HALF);
            ser_clk = 1'b1;
            idle(HALF);
            ser_clk = 1'b0;
        end
        ser_dat = 1'b0;
    endtask

    task automatic strobe(input int pulses, output logic [4:0] mask, output bit boost);
        mask = '0;
        boost = 1'b0;
        ser_stb = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk); mask |= word_upd; boost |= speedup;
        end
        for (int p = 0; p < pulses; p++) begin
            ser_dat = 1'b1;
            ser_clk = 1'b1;
            for (int k = 0; k < HALF; k++) begin
                @(negedge clk); mask |= word_upd; boost |= speedup;
            end
            ser_clk = 1'b0;
            for (int k = 0; k < HALF; k++) begin
                @(negedge clk); mask |= word_upd; boost |= speedup;
            end
        end
        ser_dat = 1'b0;
        ser_stb = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk); mask |= word_upd; boost |= speedup;
        end
    endtask

    task automatic load(input logic [31:0] v, input int n, input int pulses,
                        output logic [4:0] mask, output bit boost);
        shift_bits(v, n);
        strobe(pulses, mask, boost);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [4:0] mask;
        bit boost;

        idle(4);
        // R10 reset state
        check(word_a == 0 && word_b == 0 && word_c == 0 && word_d == 0 && word_a2 == 0,
              "R10 words zero", {8'h0, word_a}, 32'h0);
        check(word_upd == 0 && !speedup && !frame_err, "R10 flags low",
              {25'h0, word_upd, speedup, frame_err}, 32'h0);
        rst_n = 1'b1;
        idle(4);

        // R2 / R1: word A, MSB first
        load(32'h005A3C14, 24, 0, mask, boost);
        check(word_a == 24'h5A3C14, "R1 R2 word_a value", {8'h0, word_a}, 32'h005A3C14);
        check(mask == 5'b00001, "R11 A pulse", {27'h0, mask}, 32'h1);
        check(boost == 1'b1, "R7 boost on A", {31'h0, boost}, 32'h1);

        // R3: C and D
        load(32'h00123456, 24, 0, mask, boost);
        check(word_c == 24'h123456, "R3 word_c value", {8'h0, word_c}, 32'h00123456);
        check(mask == 5'b01000 && !boost, "R3 R7 C pulse no boost", {26'h0, boost, mask}, 32'h8);
        load(32'h00FEDCBB, 24, 0, mask, boost);
        check(word_d == 24'hFEDCBB, "R3 word_d value", {8'h0, word_d}, 32'h00FEDCBB);
        check(mask == 5'b10000 && !boost, "R3 R7 D pulse no boost", {26'h0, boost, mask}, 32'h10);

        // R4: B staged
        load(32'h000F0F05, 24, 0, mask, boost);
        check(word_b == 24'h0, "R4 word_b held", {8'h0, word_b}, 32'h0);
        check(mask == 5'b00000 && !boost, "R4 no pulse", {26'h0, boost, mask}, 32'h0);

        // R5: A releases B
        load(32'h0000FF00, 24, 0, mask, boost);
        check(word_b == 24'h0F0F05, "R5 B released by A", {8'h0, word_b}, 32'h000F0F05);
        check(mask == 5'b00101, "R5 A and B pulses", {27'h0, mask}, 32'h5);
        load(32'h00ABCDEC, 24, 0, mask, boost);
        check(mask == 5'b00001, "R5 stage emptied", {27'h0, mask}, 32'h1);

        // R6: A2, then B released by A2
        load(32'hCAFEBABC, 32, 0, mask, boost);
        check(word_a2 == 32'hCAFEBABC, "R6 word_a2 value", word_a2, 32'hCAFEBABC);
        check(mask == 5'b00010 && boost, "R6 R7 A2 pulse boost", {26'h0, boost, mask}, 32'h22);
        load(32'h00777771, 24, 0, mask, boost);
        load(32'h11223344, 32, 0, mask, boost);
        check(word_b == 24'h777771, "R5 B released by A2", {8'h0, word_b}, 32'h00777771);
        check(mask == 5'b00110, "R5 A2 and B pulses", {27'h0, mask}, 32'h6);

        // R9: bad frames
        load(32'h000ABCDE, 20, 0, mask, boost);
        check(frame_err == 1'b1 && mask == 0 && !boost, "R9 short frame",
              {26'h0, frame_err, mask}, 32'h20);
        load(32'h00000001, 32, 0, mask, boost);
        check(word_a2 == 32'h11223344, "R9 bad A2 ignored", word_a2, 32'h11223344);
        check(frame_err == 1'b1, "R9 error kept", {31'h0, frame_err}, 32'h1);
        load(32'h00000007, 24, 0, mask, boost);
        check(frame_err == 1'b0 && word_d == 24'h7, "R9 error cleared",
              {31'h0, frame_err}, 32'h0);

        // R8: clock pulses under strobe are ignored
        load(32'h00AAAAAA, 24, 5, mask, boost);
        check(word_c == 24'hAAAAAA, "R8 C under pulses", {8'h0, word_c}, 32'h00AAAAAA);
        load(32'h00000003, 24, 0, mask, boost);
        check(word_d == 24'h000003 && !frame_err, "R8 next word exact",
              {7'h0, frame_err, word_d}, 32'h3);

        idle(10);
        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule